// File: doc/BRIEF.md
# Move-Wide Alias Predicate

This block decides whether a bitmask-immediate encoding (size flag, N bit, 6-bit S field, 6-bit R field) yields a value that one move-with-zero or move-with-not instruction could also produce. A decoder or disassembler uses the answer to choose the move alias over the OR-immediate form. The decision uses only the S and R fields. It applies modular rotation tests against 16-bit halfword boundaries and never expands the mask.

The element must span the whole operating width, which is 64 bits when the size flag is set and 32 bits when it is clear. A short run of ones (S below 16) qualifies when the rotation leaves the run inside one aligned halfword. A short run of zeros (S at least width − 15) qualifies when R mod 16 is at most S − (width − 15). Every other S gives false.

By default the result is registered. `outValid` follows `inValid` one cycle later, and a synchronous active-high reset clears both outputs. With `REGISTERED = 0` the path is purely combinational.

Top module: `wide_move_alias`

## Requirements
- R1: While `rst` is high at a rising edge, `outValid` and `movPreferred` are 0 after that edge.
- R2: With `REGISTERED = 1`, `outValid` equals the `inValid` value sampled at the previous rising edge.
- R3: When `outValid` is 0, `movPreferred` is 0.
- R4: With `sizeFlag` = 1 (width 64), an encoding whose `immN` is 0 gives `movPreferred` = 0.
- R5: With `sizeFlag` = 0 (width 32), an encoding with `immN` = 1 or `immS[5]` = 1 gives `movPreferred` = 0.
- R6: For a shape-valid encoding with S = `immS` < 16, `movPreferred` is 1 exactly when ((−R) mod 16) ≤ 15 − S, where R = `immR`. This rule is applied before the zeros rule.
- R7: For a shape-valid encoding with S ≥ width − 15, `movPreferred` is 1 exactly when (R mod 16) ≤ S − (width − 15).
- R8: For a shape-valid encoding with 16 ≤ S < width − 15, `movPreferred` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Encoding fields are valid this cycle |
| sizeFlag | input | 1 | 1 selects 64-bit width, 0 selects 32-bit width |
| immN | input | 1 | N bit of the bitmask encoding |
| immS | input | 6 | S field (run length minus one) |
| immR | input | 6 | R field (rotate amount) |
| outValid | output | 1 | Result valid |
| movPreferred | output | 1 | 1 when the move alias is preferred |

## Verification
The bench drives every one of the 16384 encodings through a behavioural model. For ones runs the model rotates the expanded run and checks which halfword holds it. For zeros runs it checks where the rotated zero run and its two guard bits land. The corner cases sit where a run ends exactly on bit 15 of a halfword or crosses into the next one (R mod 16 of 0, 14 and 15, S of 15, 16, width − 16 and width − 15). A design that got the borrow of −R wrong would accept runs that cross a halfword boundary. A design that used one threshold for both widths would flip answers for S near 17 and 49. Idle cycles and a reset in the middle of a run check that the strobe gating holds no stale true result.

// File: rtl/wide_move_alias_pkg.sv
package wide_move_alias_pkg;
  typedef struct packed {
    logic load;
    logic clear;
  } ctrlStrobe_t;
endpackage

// File: rtl/wma_fit_rule.sv
module wma_fit_rule #(
  parameter int FIELD_W  = 6,
  parameter int HALF_LOG = 4
) (
  input  logic               sizeFlag,
  input  logic               immN,
  input  logic [FIELD_W-1:0] immS,
  input  logic [FIELD_W-1:0] immR,
  output logic               fits
);
  localparam int WIDE   = 1 << FIELD_W;
  localparam int NARROW = WIDE / 2;
  localparam int HALF   = 1 << HALF_LOG;
  localparam logic [FIELD_W:0] HALF_V       = (FIELD_W+1)'(HALF);
  localparam logic [FIELD_W:0] ONES_LIMIT   = (FIELD_W+1)'(HALF - 1);
  localparam logic [FIELD_W:0] WIDE_FLOOR   = (FIELD_W+1)'(WIDE - (HALF - 1));
  localparam logic [FIELD_W:0] NARROW_FLOOR = (FIELD_W+1)'(NARROW - (HALF - 1));

  logic [FIELD_W:0]   sVal, floorS, onesSlack, zerosSlack;
  logic [FIELD_W-1:0] negR;
  logic               shapeOk, onesCase, zerosCase, onesFit, zerosFit;

  always_comb begin
    sVal       = {1'b0, immS};
    negR       = {FIELD_W{1'b0}} - immR;
    shapeOk    = sizeFlag ? immN : ~(immN | immS[FIELD_W-1]);
    floorS     = sizeFlag ? WIDE_FLOOR : NARROW_FLOOR;
    onesCase   = sVal < HALF_V;
    zerosCase  = sVal >= floorS;
    onesSlack  = ONES_LIMIT - sVal;
    zerosSlack = sVal - floorS;
    onesFit    = (FIELD_W+1)'(negR[HALF_LOG-1:0]) <= onesSlack;
    zerosFit   = (FIELD_W+1)'(immR[HALF_LOG-1:0]) <= zerosSlack;
    fits       = shapeOk & (onesCase ? onesFit : (zerosCase & zerosFit));
  end
endmodule

// File: rtl/wma_control.sv
module wma_control
  import wide_move_alias_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output ctrlStrobe_t strobes,
  output logic        outValid
);
  always_comb begin
    strobes.load  = inValid & ~rst;
    strobes.clear = rst;
  end

  generate
    if (REGISTERED) begin : g_reg
      logic validQ;
      always_ff @(posedge clk) begin
        if (strobes.clear) validQ <= 1'b0;
        else               validQ <= strobes.load;
      end
      assign outValid = validQ;
    end else begin : g_comb
      assign outValid = strobes.load;
    end
  endgenerate
endmodule

// File: rtl/wma_datapath.sv
module wma_datapath
  import wide_move_alias_pkg::*;
#(
  parameter bit REGISTERED = 1'b1,
  parameter int FIELD_W    = 6,
  parameter int HALF_LOG   = 4
) (
  input  logic               clk,
  input  ctrlStrobe_t        strobes,
  input  logic               sizeFlag,
  input  logic               immN,
  input  logic [FIELD_W-1:0] immS,
  input  logic [FIELD_W-1:0] immR,
  output logic               movPreferred
);
  logic fits;

  wma_fit_rule #(.FIELD_W(FIELD_W), .HALF_LOG(HALF_LOG)) ruleInst (
    .sizeFlag(sizeFlag),
    .immN    (immN),
    .immS    (immS),
    .immR    (immR),
    .fits    (fits)
  );

  generate
    if (REGISTERED) begin : g_reg
      logic prefQ;
      always_ff @(posedge clk) begin
        if (strobes.clear) prefQ <= 1'b0;
        else               prefQ <= strobes.load & fits;
      end
      assign movPreferred = prefQ;
    end else begin : g_comb
      assign movPreferred = strobes.load & fits;
    end
  endgenerate
endmodule

// File: rtl/wide_move_alias.sv
module wide_move_alias
  import wide_move_alias_pkg::*;
#(
  parameter bit REGISTERED = 1'b1,
  parameter int FIELD_W    = 6,
  parameter int HALF_LOG   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic               sizeFlag,
  input  logic               immN,
  input  logic [FIELD_W-1:0] immS,
  input  logic [FIELD_W-1:0] immR,
  output logic               outValid,
  output logic               movPreferred
);
  ctrlStrobe_t strobes;

  wma_control #(.REGISTERED(REGISTERED)) ctrlInst (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  wma_datapath #(
    .REGISTERED(REGISTERED),
    .FIELD_W   (FIELD_W),
    .HALF_LOG  (HALF_LOG)
  ) dpInst (
    .clk         (clk),
    .strobes     (strobes),
    .sizeFlag    (sizeFlag),
    .immN        (immN),
    .immS        (immS),
    .immR        (immR),
    .movPreferred(movPreferred)
  );
endmodule

// File: rtl/wide_move_alias_chk.sv
module wide_move_alias_chk #(
  parameter bit REGISTERED = 1'b1,
  parameter int FIELD_W    = 6,
  parameter int HALF_LOG   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic               sizeFlag,
  input logic               immN,
  input logic [FIELD_W-1:0] immS,
  input logic [FIELD_W-1:0] immR,
  input logic               outValid,
  input logic               movPreferred
);
  localparam int WIDE = 1 << FIELD_W;
  localparam int HALF = 1 << HALF_LOG;
  localparam int TOPW = WIDE - (HALF - 1);
  localparam int TOPN = WIDE / 2 - (HALF - 1);

  logic shapeOk;
  int   sInt, floorInt;
  always_comb begin
    shapeOk  = sizeFlag ? immN : ~(immN | immS[FIELD_W-1]);
    sInt     = int'(immS);
    floorInt = sizeFlag ? TOPW : TOPN;
  end

  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> !movPreferred);

  generate
    if (REGISTERED) begin : g_reg
      assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!outValid && !movPreferred));
      assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (outValid == $past(inValid)));
      assert_wide_needs_n_R4: assert property (@(posedge clk) disable iff (rst)
        (inValid && sizeFlag && !immN) |=> !movPreferred);
      assert_narrow_shape_R5: assert property (@(posedge clk) disable iff (rst)
        (inValid && !sizeFlag && (immN || immS[FIELD_W-1])) |=> !movPreferred);
      assert_unrotated_ones_R6: assert property (@(posedge clk) disable iff (rst)
        (inValid && shapeOk && sInt < HALF && immR[HALF_LOG-1:0] == '0) |=> movPreferred);
      assert_mid_false_R8: assert property (@(posedge clk) disable iff (rst)
        (inValid && shapeOk && sInt >= HALF && sInt < floorInt) |=> !movPreferred);
    end else begin : g_comb
      assert_wide_needs_n_R4: assert property (@(posedge clk) disable iff (rst)
        (sizeFlag && !immN) |-> !movPreferred);
      assert_mid_false_R8: assert property (@(posedge clk) disable iff (rst)
        (shapeOk && sInt >= HALF && sInt < floorInt) |-> !movPreferred);
    end
  endgenerate
endmodule

bind wide_move_alias wide_move_alias_chk #(
  .REGISTERED(REGISTERED),
  .FIELD_W   (FIELD_W),
  .HALF_LOG  (HALF_LOG)
) chkInst (.*);

// File: tb/wide_move_alias_test.sv
module wide_move_alias_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic       sizeFlag = 1'b0;
  logic       immN = 1'b0;
  logic [5:0] immS = '0;
  logic [5:0] immR = '0;
  logic       outValid, movPreferred;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;
  bit  expValid = 1'b0;
  bit  expPref = 1'b0;
  string expTag = "R1";

  always #10 clk = ~clk;

  wide_move_alias uut (
    .clk(clk), .rst(rst), .inValid(inValid), .sizeFlag(sizeFlag),
    .immN(immN), .immS(immS), .immR(immR),
    .outValid(outValid), .movPreferred(movPreferred)
  );

  // true when every marked bit lies in the same aligned 16-bit halfword
  function automatic bit oneHalfword(input bit [63:0] marks, input int width);
    int home = -1;
    for (int i = 0; i < width; i++) begin
      if (marks[i]) begin
        if (home < 0) home = i / 16;
        else if (home != i / 16) return 1'b0;
      end
    end
    return 1'b1;
  endfunction

  function automatic bit modelPref(input bit sf, input bit n, input int s, input int r);
    int width = sf ? 64 : 32;
    bit [63:0] marks = '0;
    if (sf && !n) return 1'b0;
    if (!sf && (n || s >= 32)) return 1'b0;
    if (s < 16) begin
      // expand S+1 ones and rotate right by R
      for (int i = 0; i <= s; i++) marks[((i - r) % width + width) % width] = 1'b1;
      return oneHalfword(marks, width);
    end
    if (s >= width - 15) begin
      // rotated zero run plus two guard bits below it must share a halfword
      int top = ((width - 1 - r) % width + width) % width;
      for (int j = 0; j <= width - 1 - s + 1; j++) marks[((top - j) % width + width) % width] = 1'b1;
      return oneHalfword(marks, width);
    end
    return 1'b0;
  endfunction

  function automatic string classify(input bit sf, input bit n, input int s);
    int width = sf ? 64 : 32;
    if (sf && !n) return "R4";
    if (!sf && (n || s >= 32)) return "R5";
    if (s < 16) return "R6";
    if (s >= width - 15) return "R7";
    return "R8";
  endfunction

  task automatic compare();
    checks++;
    if (outValid !== expValid || movPreferred !== expPref) begin
      failures++;
      $display("FAIL %s outValid/movPreferred actual=%b/%b expected=%b/%b",
               expTag, outValid, movPreferred, expValid, expPref);
    end
  endtask

  task automatic apply(input bit v, input bit r, input bit sf, input bit n, input int s, input int ro);
    @(negedge clk);
    compare();
    rst = r; inValid = v; sizeFlag = sf; immN = n;
    immS = 6'(s); immR = 6'(ro);
    if (r) begin expValid = 0; expPref = 0; expTag = "R1"; end
    else if (!v) begin expValid = 0; expPref = 0; expTag = "R3"; end
    else begin expValid = 1; expPref = modelPref(sf, n, s, ro); expTag = classify(sf, n, s); end
  endtask

  initial begin
    int step = 0;
    expValid = 0; expPref = 0; expTag = "R1";
    apply(1, 1, 1, 1, 0, 0);   // reset with a true-looking encoding present (R1)
    apply(1, 1, 1, 1, 5, 0);
    for (int sf = 0; sf < 2; sf++)
      for (int n = 0; n < 2; n++)
        for (int s = 0; s < 64; s++)
          for (int r = 0; r < 64; r++) begin
            step++;
            if (step % 97 == 0) apply(0, 0, 1, 1, 3, 0);      // idle cycle, R3
            if (step == 5000) apply(1, 1, 1, 1, 0, 0);        // mid-run reset, R1
            apply(1, 0, sf[0], n[0], s, r);
          end
    apply(0, 0, 0, 0, 0, 0);
    apply(0, 0, 0, 0, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule